// File: doc/BRIEF.md
# Dual-Port Mailbox with Byte Interrupts

This block is a bank of mailbox registers that two agents share on one clock. The host side writes a set of inbound mailboxes and reads a set of outbound mailboxes. The local side does the reverse. Both sides use the same plain synchronous register port: a read or write strobe, an address, four byte enables and a 32-bit data word. Read data appears on the cycle after the read strobe.

A status word keeps one bit per mailbox byte. The upper half marks inbound bytes that hold unread data. The lower half marks outbound bytes that the host has drained. The local side can pick one inbound byte and one outbound byte to watch. When the host touches the watched byte, a sticky local interrupt is raised. The host side has its own sticky request flags, which the local side's mailbox activity sets. Both interrupt outputs are active low and come from registers.

Address map, shared by both ports. Address bits 3:2 give the region: 0 is the outbound mailboxes, 1 is the inbound mailboxes, 2 is control. Bits 1:0 give the mailbox number, or the control register: 0 is status, 1 is the interrupt register, 2 is the local flags.

Top module: `mbx_dual_port`

## Requirements
- R1: After a synchronous reset, `h_irq_n` and `l_irq_n` are both 1. The status word reads 0x0000FFFF (no inbound byte full, every outbound byte empty). The local configuration and every interrupt flag are zero.
- R2: Host writes to address 4+m store into inbound mailbox m, and local writes to address 0+m store into outbound mailbox m. Only the lanes whose byte enable is 1 are written. A read of that mailbox from the other port returns the stored word on the cycle after the read strobe.
- R3: Status bit 16+4m+b is set when a host write to inbound mailbox m has byte enable b. It is cleared when a local read of that mailbox has byte enable b. If both happen in the same cycle, the set wins.
- R4: Status bit 4m+b is cleared when a local write to outbound mailbox m has byte enable b. It is set when a host read of that mailbox has byte enable b. If both happen in the same cycle, the clear wins.
- R5: The local configuration word sits at local address 9. Bit 4 enables the inbound interrupt, bits 3:2 select the inbound mailbox and bits 1:0 select the byte. Bit 12 enables the outbound interrupt, bits 11:10 select the outbound mailbox and bits 9:8 select the byte. One write sets all of these fields, and a read returns them.
- R6: With bit 4 set, a host write to the selected inbound mailbox whose byte enables include the selected byte sets local flag 0. A write that misses the selected byte does not set it.
- R7: With bit 12 set, a host read of the selected outbound mailbox whose byte enables include the selected byte sets local flag 1. A read of another byte does not set it.
- R8: The local flags read at local address 10, bits 1:0. They hold until a local write to address 10 puts a 1 on the matching bit. A set in the same cycle as a clear wins. `l_irq_n` is 0 exactly while a flag is set.
- R9: Host address 9 holds request bit 16, which is set by any local write to an outbound mailbox, and bit 17, which is set by any local read of an inbound mailbox. A host write with byte enable 2 and a 1 in a bit clears that bit. A 0 leaves it unchanged. `h_irq_n` is 0 exactly while a request is set.
- R10: With the enable bits clear, no host access raises a local flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_wr | input | 1 | Host write strobe |
| h_rd | input | 1 | Host read strobe |
| h_addr | input | 4 | Host register address |
| h_be | input | 4 | Host byte enables |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, one cycle after `h_rd` |
| h_irq_n | output | 1 | Host interrupt, active low |
| l_wr | input | 1 | Local write strobe |
| l_rd | input | 1 | Local read strobe |
| l_addr | input | 4 | Local register address |
| l_be | input | 4 | Local byte enables |
| l_wdata | input | 32 | Local write data |
| l_rdata | output | 32 | Local read data, one cycle after `l_rd` |
| l_irq_n | output | 1 | Local interrupt, active low |

## Verification
The checker assumes that each port issues at most one of read or write per cycle. It also assumes the configuration word is stable in the cycle that decides a watched-byte hit. The stimulus drives every access for exactly one clock and never strobes read and write together on one port. Cycles that load the configuration word carry no host traffic. The two ports do overlap on purpose in a few cycles, so that the set-versus-clear priority rules are exercised.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int REGION_OUT = 0;
  localparam int REGION_IN  = 1;
  localparam int REGION_CTL = 2;

  localparam int CTL_STATUS = 0;
  localparam int CTL_IRQREG = 1;
  localparam int CTL_LFLAGS = 2;

  localparam int CFG_IN_EN   = 4;
  localparam int CFG_IN_LO   = 0;
  localparam int CFG_OUT_EN  = 12;
  localparam int CFG_OUT_LO  = 8;
  localparam int CFG_W       = 13;

  localparam int HREQ_OUT_BIT = 16;
  localparam int HREQ_IN_BIT  = 17;
endpackage

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int NUM_MBX = 4,
  parameter int DW      = 32,
  localparam int NB     = DW / 8,
  localparam int MW     = $clog2(NUM_MBX)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [MW-1:0] waddr,
  input  logic [NB-1:0] wbe,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [MW-1:0] raddr,
  output logic [DW-1:0] q
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] lane_mem [NUM_MBX];
    logic [7:0] lane_q;

    always_ff @(posedge clk) begin
      if (we && wbe[b]) lane_mem[waddr] <= wdata[8*b +: 8];
    end

    always_ff @(posedge clk) begin
      if (re) lane_q <= lane_mem[raddr];
    end

    assign q[8*b +: 8] = lane_q;
  end
endmodule

// File: rtl/mbx_status.sv
module mbx_status #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] in_set,
  input  logic [SW-1:0] in_clr,
  input  logic [SW-1:0] out_set,
  input  logic [SW-1:0] out_clr,
  output logic [SW-1:0] full_q,
  output logic [SW-1:0] empty_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full_q  <= '0;
      empty_q <= '1;
    end else begin
      full_q  <= (full_q & ~in_clr) | in_set;
      empty_q <= (empty_q | out_set) & ~out_clr;
    end
  end
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int SW = 16,
  localparam int SELW = $clog2(SW)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SW-1:0]     host_in_wr,
  input  logic [SW-1:0]     host_out_rd,
  input  logic              loc_out_wr_any,
  input  logic              loc_in_rd_any,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_be,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              lclr_we,
  input  logic [1:0]        lclr_bits,
  input  logic              hclr_we,
  input  logic [1:0]        hclr_bits,
  output logic [CFG_W-1:0]  cfg_q,
  output logic [1:0]        lflag_q,
  output logic [1:0]        hreq_q,
  output logic              l_irq_n,
  output logic              h_irq_n
);
  logic [SELW-1:0] in_sel, out_sel;
  logic            in_hit, out_hit;
  logic [1:0]      lflag_d, hreq_d, lset, hset, lclr, hclr;

  assign in_sel  = cfg_q[CFG_IN_LO  +: SELW];
  assign out_sel = cfg_q[CFG_OUT_LO +: SELW];
  assign in_hit  = cfg_q[CFG_IN_EN]  && host_in_wr[in_sel];
  assign out_hit = cfg_q[CFG_OUT_EN] && host_out_rd[out_sel];

  always_comb begin
    lset    = {out_hit, in_hit};
    lclr    = lclr_we ? lclr_bits : 2'b00;
    lflag_d = (lflag_q & ~lclr) | lset;
    hset    = {loc_in_rd_any, loc_out_wr_any};
    hclr    = hclr_we ? hclr_bits : 2'b00;
    hreq_d  = (hreq_q & ~hclr) | hset;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      lflag_q <= '0;
      hreq_q  <= '0;
      l_irq_n <= 1'b1;
      h_irq_n <= 1'b1;
    end else begin
      if (cfg_we && cfg_be[0]) cfg_q[7:0]       <= cfg_wdata[7:0];
      if (cfg_we && cfg_be[1]) cfg_q[CFG_W-1:8] <= cfg_wdata[CFG_W-1:8];
      lflag_q <= lflag_d;
      hreq_q  <= hreq_d;
      l_irq_n <= ~|lflag_d;
      h_irq_n <= ~|hreq_d;
    end
  end
endmodule

// File: rtl/mbx_dual_port.sv
module mbx_dual_port
  import mbx_pkg::*;
#(
  parameter int NUM_MBX = 4,
  parameter int DW      = 32,
  parameter int AW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          h_wr,
  input  logic          h_rd,
  input  logic [AW-1:0] h_addr,
  input  logic [3:0]    h_be,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  output logic          h_irq_n,
  input  logic          l_wr,
  input  logic          l_rd,
  input  logic [AW-1:0] l_addr,
  input  logic [3:0]    l_be,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq_n
);
  localparam int NB = DW / 8;
  localparam int SW = NUM_MBX * NB;
  localparam int MW = $clog2(NUM_MBX);
  localparam int RW = AW - MW;

  logic [RW-1:0] h_rgn, l_rgn;
  logic [MW-1:0] h_idx, l_idx;
  assign h_rgn = h_addr[AW-1:MW];
  assign h_idx = h_addr[MW-1:0];
  assign l_rgn = l_addr[AW-1:MW];
  assign l_idx = l_addr[MW-1:0];

  logic h_in_we, h_out_re, l_out_we, l_in_re;
  assign h_in_we  = h_wr && (h_rgn == RW'(REGION_IN));
  assign h_out_re = h_rd && (h_rgn == RW'(REGION_OUT));
  assign l_out_we = l_wr && (l_rgn == RW'(REGION_OUT));
  assign l_in_re  = l_rd && (l_rgn == RW'(REGION_IN));

  logic h_ctl_wr, l_ctl_wr;
  assign h_ctl_wr = h_wr && (h_rgn == RW'(REGION_CTL));
  assign l_ctl_wr = l_wr && (l_rgn == RW'(REGION_CTL));

  logic [SW-1:0] in_set_b, in_clr_b, out_set_b, out_clr_b;
  for (genvar m = 0; m < NUM_MBX; m++) begin : g_byte_evt
    assign in_set_b [m*NB +: NB] = (h_in_we  && h_idx == MW'(m)) ? h_be[NB-1:0] : '0;
    assign in_clr_b [m*NB +: NB] = (l_in_re  && l_idx == MW'(m)) ? l_be[NB-1:0] : '0;
    assign out_set_b[m*NB +: NB] = (h_out_re && h_idx == MW'(m)) ? h_be[NB-1:0] : '0;
    assign out_clr_b[m*NB +: NB] = (l_out_we && l_idx == MW'(m)) ? l_be[NB-1:0] : '0;
  end

  logic [DW-1:0] in_q, out_q;

  mbx_store #(.NUM_MBX(NUM_MBX), .DW(DW)) u_in_store (
    .clk(clk), .we(h_in_we), .waddr(h_idx), .wbe(h_be[NB-1:0]), .wdata(h_wdata),
    .re(l_in_re), .raddr(l_idx), .q(in_q)
  );

  mbx_store #(.NUM_MBX(NUM_MBX), .DW(DW)) u_out_store (
    .clk(clk), .we(l_out_we), .waddr(l_idx), .wbe(l_be[NB-1:0]), .wdata(l_wdata),
    .re(h_out_re), .raddr(h_idx), .q(out_q)
  );

  logic [SW-1:0] full_q, empty_q;

  mbx_status #(.SW(SW)) u_status (
    .clk(clk), .rst(rst),
    .in_set(in_set_b), .in_clr(in_clr_b),
    .out_set(out_set_b), .out_clr(out_clr_b),
    .full_q(full_q), .empty_q(empty_q)
  );

  logic [2*SW-1:0]  stat_w;
  assign stat_w = {full_q, empty_q};

  logic [CFG_W-1:0] cfg_q;
  logic [1:0]       lflag_q, hreq_q;
  logic             cfg_we, lclr_we, hclr_we;

  assign cfg_we  = l_ctl_wr && (l_idx == MW'(CTL_IRQREG));
  assign lclr_we = l_ctl_wr && (l_idx == MW'(CTL_LFLAGS)) && l_be[0];
  assign hclr_we = h_ctl_wr && (h_idx == MW'(CTL_IRQREG)) && h_be[2];

  mbx_irq #(.SW(SW)) u_irq (
    .clk(clk), .rst(rst),
    .host_in_wr(in_set_b), .host_out_rd(out_set_b),
    .loc_out_wr_any(|out_clr_b), .loc_in_rd_any(|in_clr_b),
    .cfg_we(cfg_we), .cfg_be(l_be[1:0]), .cfg_wdata(l_wdata[CFG_W-1:0]),
    .lclr_we(lclr_we), .lclr_bits(l_wdata[1:0]),
    .hclr_we(hclr_we), .hclr_bits(h_wdata[HREQ_IN_BIT:HREQ_OUT_BIT]),
    .cfg_q(cfg_q), .lflag_q(lflag_q), .hreq_q(hreq_q),
    .l_irq_n(l_irq_n), .h_irq_n(h_irq_n)
  );

  logic          h_use_mem, l_use_mem;
  logic [DW-1:0] h_reg_q, l_reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      h_use_mem <= 1'b0;
      h_reg_q   <= '0;
    end else if (h_rd) begin
      h_use_mem <= h_out_re;
      h_reg_q   <= '0;
      if (h_rgn == RW'(REGION_CTL)) begin
        if (h_idx == MW'(CTL_STATUS)) h_reg_q <= DW'(stat_w);
        if (h_idx == MW'(CTL_IRQREG)) h_reg_q <= DW'({hreq_q, 16'b0});
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      l_use_mem <= 1'b0;
      l_reg_q   <= '0;
    end else if (l_rd) begin
      l_use_mem <= l_in_re;
      l_reg_q   <= '0;
      if (l_rgn == RW'(REGION_CTL)) begin
        if (l_idx == MW'(CTL_STATUS)) l_reg_q <= DW'(stat_w);
        if (l_idx == MW'(CTL_IRQREG)) l_reg_q <= DW'(cfg_q);
        if (l_idx == MW'(CTL_LFLAGS)) l_reg_q <= DW'(lflag_q);
      end
    end
  end

  assign h_rdata = h_use_mem ? out_q : h_reg_q;
  assign l_rdata = l_use_mem ? in_q  : l_reg_q;
endmodule

// File: rtl/mbx_dual_port_chk.sv
module mbx_dual_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        h_wr,
  input logic        h_rd,
  input logic [3:0]  h_addr,
  input logic [3:0]  h_be,
  input logic        h_irq_n,
  input logic        l_wr,
  input logic [3:0]  l_addr,
  input logic [3:0]  l_be,
  input logic        l_irq_n,
  input logic [12:0] cfg_q,
  input logic [31:0] stat_w
);
  function automatic logic [3:0] nib(input logic [31:0] s, input int base, input logic [1:0] m);
    logic [31:0] t;
    t = s >> (base + 4 * int'(m));
    return t[3:0];
  endfunction

  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> (h_irq_n && l_irq_n));

  // R3
  in_full_set_chk: assert property (@(posedge clk) disable iff (rst)
    (h_wr && h_addr[3:2] == 2'd1) |=>
      ((nib(stat_w, 16, $past(h_addr[1:0])) & $past(h_be)) == $past(h_be)));

  // R4
  out_empty_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (l_wr && l_addr[3:2] == 2'd0) |=>
      ((nib(stat_w, 0, $past(l_addr[1:0])) & $past(l_be)) == 4'h0));

  // R6
  in_byte_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[4] && h_wr && h_addr == {2'd1, cfg_q[3:2]} && h_be[cfg_q[1:0]]) |=> !l_irq_n);

  // R7
  out_byte_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[12] && h_rd && h_addr == {2'd0, cfg_q[11:10]} && h_be[cfg_q[9:8]]) |=> !l_irq_n);

  // R8
  local_irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!l_irq_n && !(l_wr && l_addr == 4'd10)) |=> !l_irq_n);

  // R9
  host_irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!h_irq_n && !(h_wr && h_addr == 4'd9)) |=> !h_irq_n);
endmodule

bind mbx_dual_port mbx_dual_port_chk u_chk (
  .clk(clk), .rst(rst), .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_be(h_be),
  .h_irq_n(h_irq_n), .l_wr(l_wr), .l_addr(l_addr), .l_be(l_be), .l_irq_n(l_irq_n),
  .cfg_q(cfg_q), .stat_w(stat_w)
);

// File: tb/tb_mbx_dual_port.sv
`timescale 1ns/1ps
module tb_mbx_dual_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        h_wr = 0, h_rd = 0, l_wr = 0, l_rd = 0;
  logic [3:0]  h_addr = 0, h_be = 0, l_addr = 0, l_be = 0;
  logic [31:0] h_wdata = 0, l_wdata = 0;
  logic [31:0] h_rdata, l_rdata;
  logic        h_irq_n, l_irq_n;

  always #4 clk = ~clk;

  mbx_dual_port dut (
    .clk(clk), .rst(rst),
    .h_wr(h_wr), .h_rd(h_rd), .h_addr(h_addr), .h_be(h_be), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_irq_n(h_irq_n),
    .l_wr(l_wr), .l_rd(l_rd), .l_addr(l_addr), .l_be(l_be), .l_wdata(l_wdata),
    .l_rdata(l_rdata), .l_irq_n(l_irq_n)
  );

  typedef struct { logic [31:0] val; string tag; } exp_t;
  exp_t h_q[$];
  exp_t l_q[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: pops an expectation for every read strobe seen at a clock edge
  always @(posedge clk) begin
    automatic logic hr = h_rd;
    automatic logic lr = l_rd;
    #1;
    if (hr && h_q.size() > 0) begin
      automatic exp_t e = h_q.pop_front();
      check(h_rdata, e.val, e.tag);
    end
    if (lr && l_q.size() > 0) begin
      automatic exp_t e = l_q.pop_front();
      check(l_rdata, e.val, e.tag);
    end
  end

  task automatic h_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); h_wr = 1; h_addr = a; h_be = be; h_wdata = d;
    @(negedge clk); h_wr = 0; h_be = 0;
  endtask

  task automatic l_write(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk); l_wr = 1; l_addr = a; l_be = be; l_wdata = d;
    @(negedge clk); l_wr = 0; l_be = 0;
  endtask

  task automatic h_read(input logic [3:0] a, input logic [3:0] be, input logic [31:0] e, input string tag);
    @(negedge clk); h_rd = 1; h_addr = a; h_be = be;
    h_q.push_back('{val: e, tag: tag});
    @(negedge clk); h_rd = 0; h_be = 0;
  endtask

  task automatic l_read(input logic [3:0] a, input logic [3:0] be, input logic [31:0] e, input string tag);
    @(negedge clk); l_rd = 1; l_addr = a; l_be = be;
    l_q.push_back('{val: e, tag: tag});
    @(negedge clk); l_rd = 0; l_be = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(32'(h_irq_n), 1, "R1 h_irq_n");
    check(32'(l_irq_n), 1, "R1 l_irq_n");
    h_read(4'd8, 4'hF, 32'h0000FFFF, "R1 status");
    l_read(4'd9, 4'hF, 32'h0, "R1 cfg");

    // R5 one write programs both watched bytes: in mbx2 byte1, out mbx3 byte0
    l_write(4'd9, 4'h3, 32'h0000_1C19);
    l_read(4'd9, 4'hF, 32'h0000_1C19, "R5 cfg readback");

    // R2/R3 inbound data and full bits
    h_write(4'd4, 4'hF, 32'h1122_3344);
    check(32'(l_irq_n), 1, "R6 unselected mailbox");
    h_read(4'd8, 4'hF, 32'h000F_FFFF, "R3 full set");
    l_read(4'd4, 4'h3, 32'h1122_3344, "R2 inbound data");
    h_read(4'd8, 4'hF, 32'h000C_FFFF, "R3 full cleared per byte");

    // R9 host request from local inbound read
    check(32'(h_irq_n), 0, "R9 host irq on inbound read");
    h_read(4'd9, 4'hF, 32'h0002_0000, "R9 request bit17");
    h_write(4'd9, 4'h4, 32'h0000_0000);
    check(32'(h_irq_n), 0, "R9 writing zero keeps request");
    h_write(4'd9, 4'h4, 32'h0002_0000);
    check(32'(h_irq_n), 1, "R9 w1c clears");

    // R6 inbound watched byte
    h_write(4'd6, 4'h1, 32'h0000_00AA);
    check(32'(l_irq_n), 1, "R6 other byte no irq");
    h_write(4'd6, 4'h2, 32'h0000_BB00);
    check(32'(l_irq_n), 0, "R6 selected byte irq");
    l_read(4'd10, 4'hF, 32'h1, "R8 flag0");
    l_write(4'd10, 4'h1, 32'h0);
    check(32'(l_irq_n), 0, "R8 zero write keeps flag");
    l_write(4'd10, 4'h1, 32'h1);
    check(32'(l_irq_n), 1, "R8 w1c clears");

    // R4 outbound and R9 bit16
    l_write(4'd3, 4'hF, 32'hCAFE_F00D);
    h_read(4'd8, 4'hF, 32'h030C_0FFF, "R4 empty cleared");
    check(32'(h_irq_n), 0, "R9 host irq on outbound write");
    h_read(4'd9, 4'hF, 32'h0001_0000, "R9 request bit16");
    h_write(4'd9, 4'h4, 32'h0001_0000);
    check(32'(h_irq_n), 1, "R9 bit16 cleared");

    // R7 outbound watched byte
    h_read(4'd3, 4'h2, 32'hCAFE_F00D, "R2 outbound data");
    check(32'(l_irq_n), 1, "R7 other byte no irq");
    h_read(4'd3, 4'h1, 32'hCAFE_F00D, "R2 outbound data again");
    check(32'(l_irq_n), 0, "R7 selected byte irq");
    l_read(4'd10, 4'hF, 32'h2, "R7 flag1");
    h_read(4'd8, 4'hF, 32'h030C_3FFF, "R4 empty set by host read");

    // R8 set beats clear in the same cycle
    @(negedge clk);
    l_wr = 1; l_addr = 4'd10; l_be = 4'h1; l_wdata = 32'h2;
    h_rd = 1; h_addr = 4'd3; h_be = 4'h1;
    h_q.push_back('{val: 32'hCAFE_F00D, tag: "R2 concurrent read"});
    @(negedge clk);
    l_wr = 0; h_rd = 0; l_be = 0; h_be = 0;
    check(32'(l_irq_n), 0, "R8 set wins over clear");
    l_write(4'd10, 4'h1, 32'h2);
    check(32'(l_irq_n), 1, "R8 cleared after");

    // R4 local write beats host read on the same byte
    l_write(4'd1, 4'hF, 32'h5566_7788);
    h_write(4'd9, 4'h4, 32'h0001_0000);
    @(negedge clk);
    l_wr = 1; l_addr = 4'd1; l_be = 4'h1; l_wdata = 32'h0000_0099;
    h_rd = 1; h_addr = 4'd1; h_be = 4'h1;
    h_q.push_back('{val: 32'h5566_7788, tag: "R2 read before rewrite"});
    @(negedge clk);
    l_wr = 0; h_rd = 0; l_be = 0; h_be = 0;
    h_read(4'd8, 4'hF, 32'h030C_3F0F, "R4 clear wins");
    h_read(4'd1, 4'h2, 32'h5566_7799, "R2 byte-enabled write");

    // R10 enables off
    l_write(4'd10, 4'h1, 32'h3);
    l_write(4'd9, 4'h3, 32'h0000_0000);
    h_write(4'd6, 4'h2, 32'h0000_CC00);
    h_read(4'd3, 4'h1, 32'hCAFE_F00D, "R10 outbound read");
    check(32'(l_irq_n), 1, "R10 no local irq when disabled");
    l_read(4'd10, 4'hF, 32'h0, "R10 flags stay clear");

    repeat (3) @(negedge clk);
    check(32'(h_q.size() + l_q.size()), 0, "R2 all reads returned");
    done = 1;
    finish_run();
  end
endmodule